// File: doc/BRIEF.md
# Sticky Carry and Overflow Status Unit

This block keeps the carry bit and the signed-overflow bit of a small processor, together with the add/subtract datapath that feeds them. Two operands go into the datapath. A mode bit chooses between addition and subtraction. The datapath returns the sum, its carry-out and its signed-overflow indication as combinational outputs.

The instruction sequencer issues a separate command to each flag register on every cycle. The carry register can keep its value, clear, set, take the carry-out, or take the inverted carry-out. The overflow register can keep its value, clear, set, or accumulate. Accumulate only ever raises the flag. A run of arithmetic can therefore be checked for overflow once, at its end, and only an explicit clear lowers the flag again.

A typical add sequence clears carry in one cycle. In the next cycle it presents the operands with carry load and overflow accumulate both active.

Top module: `sticky_flag_unit`

## Requirements
- R1: With `sub_mode` low, `sum` equals the low WIDTH bits of `op_a + op_b` with a carry-in of 0, and `carry_out` is bit WIDTH of that full sum.
- R2: With `sub_mode` high, `sum` and `carry_out` are the low WIDTH bits and bit WIDTH of `op_a + ~op_b + 1`.
- R3: `ovf_raw` is high exactly when `op_a` and the effective second operand have the same sign bit and `sum` has the other sign bit. The effective second operand is `~op_b` when subtracting and `op_b` otherwise.
- R4: Carry command 1 clears `carry_flag` and carry command 2 sets it, at the next rising edge.
- R5: Carry command 3 loads `carry_out` into `carry_flag`, and carry command 4 loads its inverse, at the next rising edge.
- R6: Carry command 0 and the unused codes 5, 6 and 7 leave `carry_flag` unchanged.
- R7: Overflow command 0 holds `ovf_flag`, command 1 clears it and command 2 sets it.
- R8: Overflow command 3 sets `ovf_flag` when `ovf_raw` is high and never clears it; an operation that does not overflow leaves the flag as it was.
- R9: While `rst_n` is low at a rising edge, both flags become 0, whatever commands are present.
- R10: The flags are registers: a command changes a flag only at the next rising edge, never in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub_mode | input | 1 | High selects subtraction |
| carry_cmd | input | 3 | Carry command: 0 hold, 1 clear, 2 set, 3 load, 4 load inverted, 5-7 hold |
| ovf_cmd | input | 2 | Overflow command: 0 hold, 1 clear, 2 set, 3 accumulate |
| sum | output | WIDTH | Datapath result |
| carry_out | output | 1 | Carry-out of the datapath |
| ovf_raw | output | 1 | Signed overflow of the current operation |
| carry_flag | output | 1 | Registered carry flag |
| ovf_flag | output | 1 | Registered sticky overflow flag |

## Verification
The bench builds the unit with WIDTH set to 4. At that width every operand pair and both modes can be swept. That covers every sign combination that produces or avoids overflow, and every carry-out case, including the borrow-free equal-operand subtraction.

For each operation the bench first seeds both flags to a known level. It then applies every carry command and every overflow command, so that each command is checked starting from both a 0 and a 1 flag. The unused carry codes are included in that sweep. Reset is checked with set commands present, and the one-edge latency is checked by sampling a flag before and after a single edge.

// File: rtl/sfu_pkg.sv
// sfu_pkg: shared command encodings for the sticky flag unit.
// Assumes commands are driven as plain vectors and cast to these types.
package sfu_pkg;

    localparam int CCMD_W = 3;
    localparam int OCMD_W = 2;

    typedef enum logic [CCMD_W-1:0] {
        CC_HOLD  = 3'd0,
        CC_CLEAR = 3'd1,
        CC_SET   = 3'd2,
        CC_LOAD  = 3'd3,
        CC_LOADN = 3'd4
    } carry_cmd_e;

    typedef enum logic [OCMD_W-1:0] {
        OC_HOLD  = 2'd0,
        OC_CLEAR = 2'd1,
        OC_SET   = 2'd2,
        OC_ACCUM = 2'd3
    } ovf_cmd_e;

endpackage

// File: rtl/sfu_addsub.sv
// sfu_addsub: combinational WIDTH-bit adder/subtractor.
// Addition uses a carry-in of 0. Subtraction is formed as a + ~b + 1.
// Signed overflow is taken from the operand and result sign bits.
module sfu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] y,
    output logic             co,
    output logic             ov
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    // Select the effective second operand and form the extended sum.
    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        y     = full[MSB:0];
        co    = full[WIDTH];
        ov    = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
    end
endmodule

// File: rtl/sfu_carry_reg.sv
// sfu_carry_reg: carry flag register driven by a per-cycle command.
// Assumes a synchronous active-low reset; unused codes hold the flag.
module sfu_carry_reg
    import sfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CCMD_W-1:0] cmd,
    input  logic              co,
    output logic              q
);
    // Update the carry flag according to the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            case (carry_cmd_e'(cmd))
                CC_CLEAR: q <= 1'b0;
                CC_SET:   q <= 1'b1;
                CC_LOAD:  q <= co;
                CC_LOADN: q <= ~co;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/sfu_ovf_reg.sv
// sfu_ovf_reg: sticky overflow flag register.
// The accumulate command can only raise the flag; only clear lowers it.
module sfu_ovf_reg
    import sfu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OCMD_W-1:0] cmd,
    input  logic              ov,
    output logic              q
);
    // Update the overflow flag according to the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            case (ovf_cmd_e'(cmd))
                OC_CLEAR: q <= 1'b0;
                OC_SET:   q <= 1'b1;
                OC_ACCUM: if (!q) q <= ov;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/sticky_flag_unit.sv
// sticky_flag_unit: add/subtract datapath with a command-driven carry flag
// and a sticky overflow flag. Commands come from an external sequencer
// and take effect at the next rising edge.
module sticky_flag_unit
    import sfu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic              sub_mode,
    input  logic [CCMD_W-1:0] carry_cmd,
    input  logic [OCMD_W-1:0] ovf_cmd,
    output logic [WIDTH-1:0]  sum,
    output logic              carry_out,
    output logic              ovf_raw,
    output logic              carry_flag,
    output logic              ovf_flag
);
    // Arithmetic datapath.
    sfu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a   (op_a),
        .b   (op_b),
        .sub (sub_mode),
        .y   (sum),
        .co  (carry_out),
        .ov  (ovf_raw)
    );

    // Carry flag.
    sfu_carry_reg u_carry (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (carry_cmd),
        .co    (carry_out),
        .q     (carry_flag)
    );

    // Overflow flag.
    sfu_ovf_reg u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (ovf_cmd),
        .ov    (ovf_raw),
        .q     (ovf_flag)
    );
endmodule

// File: rtl/sticky_flag_unit_chk.sv
// sticky_flag_unit_chk: temporal checks on the flag registers, bound to
// every instance of sticky_flag_unit.
module sticky_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] carry_cmd,
    input logic [1:0] ovf_cmd,
    input logic       carry_out,
    input logic       ovf_raw,
    input logic       carry_flag,
    input logic       ovf_flag
);
    // R4
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_cmd == 3'd1 |=> !carry_flag);
    // R4
    carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_cmd == 3'd2 |=> carry_flag);
    // R5
    carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_cmd == 3'd3 |=> carry_flag == $past(carry_out));
    // R5
    carry_loadn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_cmd == 3'd4 |=> carry_flag == !$past(carry_out));
    // R6
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_cmd == 3'd0 || carry_cmd >= 3'd5) |=> $stable(carry_flag));
    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_cmd == 2'd0 |=> $stable(ovf_flag));
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cmd == 2'd3 && ovf_flag) |=> ovf_flag);
    // R8
    ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cmd == 2'd3 && ovf_raw) |=> ovf_flag);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!carry_flag && !ovf_flag));
endmodule

bind sticky_flag_unit sticky_flag_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carry_cmd  (carry_cmd),
    .ovf_cmd    (ovf_cmd),
    .carry_out  (carry_out),
    .ovf_raw    (ovf_raw),
    .carry_flag (carry_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/test_sticky_flag_unit.sv
// Exhaustive bench at WIDTH=4: every operand pair, both modes, every
// command pair, from both seeded flag levels.
module test_sticky_flag_unit;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_mode = 1'b0;
    logic [2:0]   carry_cmd = 3'd0;
    logic [1:0]   ovf_cmd = 2'd0;
    logic [W-1:0] sum;
    logic         carry_out, ovf_raw, carry_flag, ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sticky_flag_unit #(.WIDTH(W)) i_sticky_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .sub_mode(sub_mode), .carry_cmd(carry_cmd), .ovf_cmd(ovf_cmd),
        .sum(sum), .carry_out(carry_out), .ovf_raw(ovf_raw),
        .carry_flag(carry_flag), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R9: reset wins over set commands.
        carry_cmd = 3'd2;
        ovf_cmd   = 2'd2;
        repeat (2) @(negedge clk);
        check("R9 carry", carry_flag, 0);
        check("R9 ovf", ovf_flag, 0);
        carry_cmd = 3'd0;
        ovf_cmd   = 2'd0;
        rst_n     = 1'b1;
        @(negedge clk);

        // R10: no change before the edge, change after it.
        carry_cmd = 3'd2;
        ovf_cmd   = 2'd2;
        #1;
        check("R10 carry before edge", carry_flag, 0);
        check("R10 ovf before edge", ovf_flag, 0);
        @(negedge clk);
        check("R10 carry after edge", carry_flag, 1);
        check("R10 ovf after edge", ovf_flag, 1);

        for (int p = 0; p < 2; p++)
        for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
        for (int s = 0; s < 2; s++)
        for (int cc = 0; cc < 8; cc++)
        for (int oc = 0; oc < 4; oc++) begin
            int bb, full, e_sum, e_co, e_ov, e_c, e_o;
            string ct, ot;
            // Seed both flags to level p.
            carry_cmd = (p != 0) ? 3'd2 : 3'd1;
            ovf_cmd   = (p != 0) ? 2'd2 : 2'd1;
            @(negedge clk);
            op_a = a[W-1:0];
            op_b = b[W-1:0];
            sub_mode = s[0];
            carry_cmd = cc[2:0];
            ovf_cmd = oc[1:0];
            bb    = (s != 0) ? (~b & 15) : b;
            full  = a + bb + s;
            e_sum = full & 15;
            e_co  = (full >> 4) & 1;
            e_ov  = ((a >> 3) == (bb >> 3) && (e_sum >> 3) != (a >> 3)) ? 1 : 0;
            #1;
            if (cc == 0 && oc == 0) begin
                check((s != 0) ? "R2 sum" : "R1 sum", int'(sum), e_sum);
                check((s != 0) ? "R2 carry_out" : "R1 carry_out", int'(carry_out), e_co);
                check("R3 ovf_raw", int'(ovf_raw), e_ov);
            end
            case (cc)
                1: begin e_c = 0; ct = "R4 carry clear"; end
                2: begin e_c = 1; ct = "R4 carry set"; end
                3: begin e_c = e_co; ct = "R5 carry load"; end
                4: begin e_c = 1 - e_co; ct = "R5 carry load inverted"; end
                default: begin e_c = p; ct = "R6 carry hold"; end
            endcase
            case (oc)
                1: begin e_o = 0; ot = "R7 ovf clear"; end
                2: begin e_o = 1; ot = "R7 ovf set"; end
                3: begin e_o = p | e_ov; ot = "R8 ovf accumulate"; end
                default: begin e_o = p; ot = "R7 ovf hold"; end
            endcase
            @(negedge clk);
            check(ct, int'(carry_flag), e_c);
            check(ot, int'(ovf_flag), e_o);
        end
        finish_run();
    end
endmodule